// File: doc/BRIEF.md
# Fractional Saturating Multiply-Accumulate Unit

This block is a single-cycle multiply-accumulate datapath for signed 1.15 fractional voice samples. Each accepted operation forms the signed product of two 16-bit operands and shifts it left by one bit into 1.31 format. It then writes that value into a 32-bit accumulator, adds it to the accumulator or subtracts it from the accumulator. Each of these steps clips to the signed 32-bit range instead of wrapping. The only product that cannot be represented is minus one times minus one, so that case clips to the largest positive value.

Alongside the accumulator, the block registers a 16-bit fractional result taken from the accumulator's upper half. That result can optionally be rounded to nearest, and the rounding step also saturates. A sticky flag records every clipping event until it is cleared explicitly. An operation is accepted on any rising clock edge where the valid strobe is high. Its results appear on the outputs directly after that edge.

Top module: `frac_mac`

## Requirements
- R1: While reset is asserted, and after it is released, the accumulator, the 16-bit result and the overflow flag are all zero.
- R2: With op code 3'b000 (multiply), the accumulator after the accepting edge equals the signed product of the two operands shifted left by one bit.
- R3: When both operands of a product are 16'h8000, that product is 32'h7FFFFFFF and the overflow flag sets. This holds in multiply, MAC and MSU operations.
- R4: With op code 3'b001 (MAC), the accumulator becomes accumulator plus product. The sum is clipped to 32'h7FFFFFFF or 32'h80000000 when it leaves the signed 32-bit range.
- R5: With op code 3'b010 (MSU), the accumulator becomes accumulator minus product, and it clips the same way as R4.
- R6: With op code 3'b011, the accumulator and the 16-bit result become zero.
- R7: With op code 3'b100, the accumulator is loaded with the 32-bit load input.
- R8: The 16-bit result is bits [31:16] of the new accumulator when rounding is off. When rounding is on, it is bits [31:16] of the new accumulator plus 32'h00008000, with that addition clipped at 32'h7FFFFFFF.
- R9: Every clipping event (product, sum or rounding) in an accepted operation sets the overflow flag. The flag stays set until clr_flag_i is high at an edge. If a new event occurs at that same edge, the flag stays set.
- R10: Without valid_i, the accumulator and the result hold their values. Op codes 3'b101 to 3'b111 leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Accept the operation on this edge |
| op_i | input | 3 | Operation code |
| a_i | input | 16 | Operand A, 1.15 signed |
| b_i | input | 16 | Operand B, 1.15 signed |
| load_i | input | 32 | Direct accumulator load value |
| round_en_i | input | 1 | Round the 16-bit result to nearest |
| clr_flag_i | input | 1 | Clear the sticky overflow flag |
| acc_o | output | 32 | Accumulator, 1.31 signed |
| res_o | output | 16 | Result, 1.15 signed |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench targets the minus-one-squared product. A design that multiplies without that special case would return 32'h80000000 and leave the flag clear. It drives sums and differences across both ends of the range, where a wrapping adder would flip the sign of the accumulator. It also rounds values whose low half sits at 32'h8000 and 32'h7FFF: one carry into the upper half is legal, another saturates, and an off-by-one rounding constant or a missing clip would give the wrong upper half. Finally, it pulses clear together with a fresh overflow, and it sends reserved codes and cycles without valid, to catch a flag that drops or an accumulator that moves when it should hold.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;
  typedef enum logic [2:0] {
    OP_MUL  = 3'b000,
    OP_MAC  = 3'b001,
    OP_MSU  = 3'b010,
    OP_CLR  = 3'b011,
    OP_LOAD = 3'b100
  } mac_op_e;
endpackage

// File: rtl/frac_mul.sv
module frac_mul #(
  parameter int DATA_W = 16,
  localparam int ACC_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [ACC_W-1:0]  prod_o,
  output logic              sat_o
);
  localparam logic [DATA_W-1:0] D_MIN = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [ACC_W-1:0]  A_MAX = {1'b0, {(ACC_W-1){1'b1}}};

  logic signed [ACC_W-1:0] raw;

  always_comb begin
    raw = ACC_W'($signed(a_i)) * ACC_W'($signed(b_i));
    // only -1 * -1 leaves the range after the doubling shift
    sat_o  = (a_i == D_MIN) && (b_i == D_MIN);
    prod_o = sat_o ? A_MAX : {raw[ACC_W-2:0], 1'b0};
  end
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         sat_o
);
  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] ext;

  always_comb begin
    if (sub_i) ext = {x_i[W-1], x_i} - {y_i[W-1], y_i};
    else       ext = {x_i[W-1], x_i} + {y_i[W-1], y_i};
    // guard bit disagreeing with sign bit means the true result left the range
    sat_o = ext[W] ^ ext[W-1];
    if (!sat_o)      sum_o = ext[W-1:0];
    else if (ext[W]) sum_o = S_MIN;
    else             sum_o = S_MAX;
  end
endmodule

// File: rtl/frac_round.sv
module frac_round #(
  parameter int DATA_W = 16,
  localparam int ACC_W = 2 * DATA_W
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic              en_i,
  output logic [DATA_W-1:0] res_o,
  output logic              sat_o
);
  localparam logic [ACC_W-1:0] HALF = {{(ACC_W-1){1'b0}}, 1'b1} << (DATA_W-1);

  logic [ACC_W-1:0] rnd_sum;
  logic             rnd_sat;

  sat_addsub #(.W(ACC_W)) i_rnd_add (
    .x_i   (acc_i),
    .y_i   (HALF),
    .sub_i (1'b0),
    .sum_o (rnd_sum),
    .sat_o (rnd_sat)
  );

  always_comb begin
    res_o = en_i ? rnd_sum[ACC_W-1 -: DATA_W] : acc_i[ACC_W-1 -: DATA_W];
    sat_o = en_i & rnd_sat;
  end
endmodule

// File: rtl/frac_mac.sv
module frac_mac
  import frac_mac_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ACC_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [ACC_W-1:0]  load_i,
  input  logic              round_en_i,
  input  logic              clr_flag_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic [DATA_W-1:0] res_o,
  output logic              ovf_o
);
  localparam logic [DATA_W-1:0] D_MIN = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [ACC_W-1:0]  A_MAX = {1'b0, {(ACC_W-1){1'b1}}};

  mac_op_e          op;
  logic [ACC_W-1:0] prod, sum, acc_q, acc_nxt;
  logic             mul_sat, add_sat, rnd_sat, event_sat;
  logic [DATA_W-1:0] res_q, res_nxt;
  logic             ovf_q;

  assign op = mac_op_e'(op_i);

  frac_mul #(.DATA_W(DATA_W)) i_mul (
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod),
    .sat_o  (mul_sat)
  );

  sat_addsub #(.W(ACC_W)) i_acc_add (
    .x_i   (acc_q),
    .y_i   (prod),
    .sub_i (op == OP_MSU),
    .sum_o (sum),
    .sat_o (add_sat)
  );

  always_comb begin
    acc_nxt   = acc_q;
    event_sat = 1'b0;
    unique case (op)
      OP_MUL: begin
        acc_nxt   = prod;
        event_sat = mul_sat;
      end
      OP_MAC, OP_MSU: begin
        acc_nxt   = sum;
        event_sat = mul_sat | add_sat;
      end
      OP_CLR:  acc_nxt = '0;
      OP_LOAD: acc_nxt = load_i;
      default: acc_nxt = acc_q;
    endcase
  end

  frac_round #(.DATA_W(DATA_W)) i_round (
    .acc_i (acc_nxt),
    .en_i  (round_en_i),
    .res_o (res_nxt),
    .sat_o (rnd_sat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      res_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (valid_i) begin
        acc_q <= acc_nxt;
        res_q <= res_nxt;
      end
      // a fresh event outranks a clear at the same edge
      ovf_q <= (ovf_q & ~clr_flag_i) | (valid_i & (event_sat | rnd_sat));
    end
  end

  assign acc_o = acc_q;
  assign res_o = res_q;
  assign ovf_o = ovf_q;

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(acc_o) && $stable(res_o));

  assert_reserved_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i > 3'b100) |=> $stable(acc_o));

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_CLR) |=> (acc_o == '0) && (res_o == '0));

  assert_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_LOAD) |=> acc_o == $past(load_i));

  assert_min_square_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == OP_MUL) && (a_i == D_MIN) && (b_i == D_MIN)
    |=> (acc_o == A_MAX) && ovf_o);

  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !clr_flag_i |=> ovf_o);

  assert_flag_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_flag_i && !valid_i |=> !ovf_o);
endmodule

// File: tb/test_frac_mac.sv
module test_frac_mac;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [31:0] load_i = '0;
  logic        round_en_i = 1'b0, clr_flag_i = 1'b0;
  logic [31:0] acc_o;
  logic [15:0] res_o;
  logic        ovf_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  frac_mac i_frac_mac (
    .clk_i, .rst_ni, .valid_i, .op_i, .a_i, .b_i, .load_i,
    .round_en_i, .clr_flag_i, .acc_o, .res_o, .ovf_o
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] a;
    logic [15:0] b;
    logic [31:0] ld;
    logic        rnd;
    logic [31:0] e_acc;
    logic [15:0] e_res;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 16'h4000, 16'h4000, 32'h0,        1'b0, 32'h20000000, 16'h2000},
    '{3'd1, 16'h4000, 16'h4000, 32'h0,        1'b0, 32'h40000000, 16'h4000},
    '{3'd2, 16'h2000, 16'h4000, 32'h0,        1'b0, 32'h30000000, 16'h3000},
    '{3'd0, 16'h0003, 16'h0005, 32'h0,        1'b1, 32'h0000001E, 16'h0000},
    '{3'd0, 16'hFFFF, 16'h0001, 32'h0,        1'b0, 32'hFFFFFFFE, 16'hFFFF},
    '{3'd4, 16'h0,    16'h0,    32'h12348000, 1'b1, 32'h12348000, 16'h1235},
    '{3'd4, 16'h0,    16'h0,    32'h7FFF0000, 1'b0, 32'h7FFF0000, 16'h7FFF},
    '{3'd3, 16'h1234, 16'h5678, 32'h0,        1'b1, 32'h00000000, 16'h0000},
    '{3'd2, 16'h4000, 16'hC000, 32'h0,        1'b0, 32'h20000000, 16'h2000},
    '{3'd1, 16'h8000, 16'h4000, 32'h0,        1'b0, 32'hE0000000, 16'hE000},
    '{3'd4, 16'h0,    16'h0,    32'hFFFF7FFF, 1'b1, 32'hFFFF7FFF, 16'hFFFF},
    '{3'd4, 16'h0,    16'h0,    32'hFFFF8000, 1'b1, 32'hFFFF8000, 16'h0000}
  };

  function automatic string op_tag(logic [2:0] op);
    case (op)
      3'd0:    return "R2";
      3'd1:    return "R4";
      3'd2:    return "R5";
      3'd3:    return "R6";
      3'd4:    return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one accepted operation; outputs sampled at the following falling edge
  task automatic do_op(logic [2:0] op, logic [15:0] a, logic [15:0] b,
                       logic [31:0] ld, logic rnd, logic clr);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; a_i = a; b_i = b; load_i = ld;
    round_en_i = rnd; clr_flag_i = clr;
    @(negedge clk_i);
    valid_i = 1'b0; clr_flag_i = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk_i);
    clr_flag_i = 1'b1;
    @(negedge clk_i);
    clr_flag_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 acc in reset", acc_o, 32'h0);
    chk("R1 flag in reset", {31'h0, ovf_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 acc after reset", acc_o, 32'h0);
    chk("R1 res after reset", {16'h0, res_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      do_op(TBL[i].op, TBL[i].a, TBL[i].b, TBL[i].ld, TBL[i].rnd, 1'b0);
      chk(op_tag(TBL[i].op), acc_o, TBL[i].e_acc);
      chk("R8 table result", {16'h0, res_o}, {16'h0, TBL[i].e_res});
      chk("R9 no spurious flag", {31'h0, ovf_o}, 32'h0);
    end

    // R3 minus one squared
    do_op(3'd0, 16'h8000, 16'h8000, 32'h0, 1'b0, 1'b0);
    chk("R3 product", acc_o, 32'h7FFFFFFF);
    chk("R3 flag", {31'h0, ovf_o}, 32'h1);
    // R9 flag holds, then clears
    repeat (2) @(negedge clk_i);
    chk("R9 sticky", {31'h0, ovf_o}, 32'h1);
    clear_flag();
    chk("R9 cleared", {31'h0, ovf_o}, 32'h0);
    chk("R9 clear keeps acc", acc_o, 32'h7FFFFFFF);

    // R3 inside MAC
    do_op(3'd3, 16'h0, 16'h0, 32'h0, 1'b0, 1'b0);
    do_op(3'd1, 16'h8000, 16'h8000, 32'h0, 1'b0, 1'b0);
    chk("R3 mac product", acc_o, 32'h7FFFFFFF);
    chk("R3 mac flag", {31'h0, ovf_o}, 32'h1);
    clear_flag();

    // R4 positive and negative clipping
    do_op(3'd4, 16'h0, 16'h0, 32'h7FFF0000, 1'b0, 1'b0);
    do_op(3'd1, 16'h4000, 16'h4000, 32'h0, 1'b0, 1'b0);
    chk("R4 positive clip", acc_o, 32'h7FFFFFFF);
    chk("R4 positive flag", {31'h0, ovf_o}, 32'h1);
    clear_flag();
    do_op(3'd4, 16'h0, 16'h0, 32'h80000000, 1'b0, 1'b0);
    do_op(3'd1, 16'h8000, 16'h4000, 32'h0, 1'b0, 1'b0);
    chk("R4 negative clip", acc_o, 32'h80000000);
    chk("R4 negative result", {16'h0, res_o}, 32'h8000);
    chk("R4 negative flag", {31'h0, ovf_o}, 32'h1);
    clear_flag();

    // R5 subtraction clipping both ways
    do_op(3'd4, 16'h0, 16'h0, 32'h80000000, 1'b0, 1'b0);
    do_op(3'd2, 16'h4000, 16'h4000, 32'h0, 1'b0, 1'b0);
    chk("R5 negative clip", acc_o, 32'h80000000);
    chk("R5 negative flag", {31'h0, ovf_o}, 32'h1);
    clear_flag();
    do_op(3'd4, 16'h0, 16'h0, 32'h7FFFFFFF, 1'b0, 1'b0);
    do_op(3'd2, 16'h8000, 16'h4000, 32'h0, 1'b0, 1'b0);
    chk("R5 positive clip", acc_o, 32'h7FFFFFFF);
    chk("R5 positive flag", {31'h0, ovf_o}, 32'h1);
    clear_flag();

    // R8 rounding that saturates
    do_op(3'd4, 16'h0, 16'h0, 32'h7FFF8000, 1'b1, 1'b0);
    chk("R8 round clip acc", acc_o, 32'h7FFF8000);
    chk("R8 round clip result", {16'h0, res_o}, 32'h7FFF);
    chk("R9 round event flag", {31'h0, ovf_o}, 32'h1);

    // R9 clear together with a new event keeps the flag
    do_op(3'd0, 16'h8000, 16'h8000, 32'h0, 1'b0, 1'b1);
    chk("R9 clear vs event", {31'h0, ovf_o}, 32'h1);
    clear_flag();
    chk("R9 cleared again", {31'h0, ovf_o}, 32'h0);

    // R10 no valid: inputs move but state holds
    do_op(3'd4, 16'h0, 16'h0, 32'h11112222, 1'b0, 1'b0);
    @(negedge clk_i);
    op_i = 3'd4; load_i = 32'hDEADBEEF; a_i = 16'h8000; b_i = 16'h8000;
    repeat (2) @(negedge clk_i);
    chk("R10 hold acc", acc_o, 32'h11112222);
    chk("R10 hold res", {16'h0, res_o}, 32'h1111);
    // reserved codes
    for (int c = 5; c < 8; c++) begin
      do_op(3'(c), 16'h8000, 16'h8000, 32'hDEADBEEF, 1'b0, 1'b0);
      chk("R10 reserved op acc", acc_o, 32'h11112222);
      chk("R10 reserved op flag", {31'h0, ovf_o}, 32'h0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule